// File: doc/BRIEF.md
# SPI Master with Programmable Header Phase

This block is a single-lane SPI master. A transfer is a fixed sequence of phases. First comes an optional header: instruction bytes, then address bytes, then dummy bytes. The data words queued in a write FIFO follow. Last comes an optional read phase that gathers a programmed number of bytes into a read FIFO. Each header byte count can be set separately, so a payload whose length is not a multiple of four can be split. The first one to three bytes travel in the address field, and the rest go out as whole 32-bit FIFO words. No padding byte ever reaches the line.

The configuration arrives on plain input ports: header values, byte counts, read length, clock divider and capture edge. These are latched when `go` is accepted while the block is idle. `ready` stays high only while the controller is idle. Chip select is driven directly from an enable input. A flush input empties both FIFOs at once.

The controller FSM has six states:
- `PH_IDLE`: waits for `go`.
- `PH_INST`, `PH_ADDR`, `PH_DUMMY`: the header states.
- `PH_DATA`: sends write-FIFO words.
- `PH_READ`: captures read bytes.

On `go`, and whenever a phase runs out, the FSM takes the transition to the next phase in that fixed order whose byte count is non-zero. An empty write FIFO counts as an empty `PH_DATA` phase. If no later phase is non-empty, the FSM returns to `PH_IDLE`. Within a phase, the FSM stays in the same state and launches one byte per completed byte. `PH_DATA` pops a word after its fourth byte.

Top module: `spi_hdr_master`

## Requirements
- R1: A transfer sends its phases in the order instruction, address, dummy, write data, read. A phase with a zero count, or a data phase with an empty write FIFO, is skipped. A transfer with nothing to send leaves the line untouched.
- R2: Instruction and address counts range from 0 to 4. For a count N, bits [8N-1:8N-8] of the field are sent first and bits [7:0] last.
- R3: Each dummy byte drives MOSI as 0xFF.
- R4: Every word in the write FIFO is sent as exactly four bytes, in little-endian order: bits [7:0] first, [31:24] last. All header bytes precede the first data byte.
- R5: The write FIFO holds 8 words and raises `wf_full` when it holds 8. A push while full is dropped, so only the first 8 words are sent.
- R6: A `flush` pulse empties both the write FIFO and the read FIFO.
- R7: The read phase clocks `rd_len` bytes, driving MOSI as 0xFF. It stores each received byte in the read FIFO, with the first received bit as bit 7.
- R8: `ready` is 1 only when the controller is idle. It drops in the cycle after an accepted `go` that has something to send. A `go` during a transfer is ignored.
- R9: When `cap_fall` is 0, MISO is sampled at the rising SCLK edge. When it is 1, MISO is sampled at the falling edge.
- R10: SCLK idles low. Each high and low half period lasts `clk_div`+1 clock cycles. Bits leave MSB first, and MOSI is stable while SCLK is high.
- R11: After reset, `ready`=1, SCLK=0, MOSI=1, `wf_full`=0 and `rf_empty`=1.
- R12: `spi_cs_n` is the inverse of `cs_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_en | input | 1 | Chip select enable |
| cap_fall | input | 1 | 1: sample MISO on falling SCLK edge |
| clk_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| inst_data | input | 32 | Instruction field |
| inst_cnt | input | 3 | Instruction byte count (0..4) |
| addr_data | input | 32 | Address field |
| addr_cnt | input | 3 | Address byte count (0..4) |
| dummy_cnt | input | 3 | Dummy byte count (0..7) |
| rd_len | input | RDLEN_W | Number of bytes to read |
| go | input | 1 | Start pulse, taken only when idle |
| flush | input | 1 | Empty both FIFOs |
| wf_wr | input | 1 | Write FIFO push |
| wf_wdata | input | 32 | Word to push |
| wf_full | output | 1 | Write FIFO full |
| rf_rd | input | 1 | Read FIFO pop |
| rf_rdata | output | 8 | Head of read FIFO |
| rf_empty | output | 1 | Read FIFO empty |
| ready | output | 1 | Controller idle |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The sweep covers every combination of instruction count 0–2, address count 0–4, dummy count 0–1, zero to two queued words and read length 0 or 3. Capture edge and divider alternate across the transfers. Address counts 1–3 in front of whole words show that unaligned payloads go out with no pad bytes. Zero counts show the skipping of each phase. The bench compares the full MOSI byte stream against an arithmetic model. The serial slave model changes MISO on the edge opposite the selected capture edge, so sampling on the wrong edge returns different read bytes.

Directed runs cover the remaining cases:
- an overfilled write FIFO
- a flush that drops both queued words and unread bytes
- a second `go` issued mid-transfer

// File: rtl/spi_hdr_pkg.sv
package spi_hdr_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int HDR_MAX    = 4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_INST  = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DUMMY = 3'd3,
        PH_DATA  = 3'd4,
        PH_READ  = 3'd5
    } phase_t;
endpackage

// File: rtl/spi_hdr_fifo.sv
module spi_hdr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> count == $past(count));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/spi_hdr_byte_eng.sv
module spi_hdr_byte_eng #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       tx_byte,
    input  logic [DIV_W-1:0] div,
    input  logic             cap_fall,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx_byte,
    output logic             sclk,
    output logic             mosi
);
    logic             half;
    logic [2:0]       bitn;
    logic [DIV_W-1:0] divc;
    logic [7:0]       sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            half    <= 1'b0;
            bitn    <= '0;
            divc    <= '0;
            sh      <= 8'hFF;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    sh   <= tx_byte;
                    half <= 1'b0;
                    bitn <= '0;
                    divc <= '0;
                end
            end else if (divc != div) begin
                divc <= divc + DIV_W'(1);
            end else begin
                divc <= '0;
                if (!half) begin
                    half <= 1'b1;
                    if (!cap_fall) rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    half <= 1'b0;
                    if (cap_fall) rx_byte <= {rx_byte[6:0], miso};
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sh   <= {sh[6:0], 1'b1};
                    end
                end
            end
        end
    end

    assign sclk = half;
    assign mosi = busy ? sh[7] : 1'b1;

    assert_sclk_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    assert_mosi_hold_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_hdr_ctrl.sv
module spi_hdr_ctrl
    import spi_hdr_pkg::*;
#(
    parameter int RDLEN_W = 6,
    parameter int WCNT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [31:0]        inst_data,
    input  logic [2:0]         inst_cnt,
    input  logic [31:0]        addr_data,
    input  logic [2:0]         addr_cnt,
    input  logic [2:0]         dummy_cnt,
    input  logic [RDLEN_W-1:0] rd_len,
    input  logic [31:0]        wf_rdata,
    input  logic [WCNT_W-1:0]  wf_count,
    output logic               wf_pop,
    output logic               rf_push,
    output logic [7:0]         rf_wdata,
    output logic               eng_start,
    output logic [7:0]         eng_tx,
    input  logic               eng_busy,
    input  logic               eng_done,
    input  logic [7:0]         eng_rx,
    output logic               ready
);
    phase_t             state;
    logic               launched;
    logic [2:0]         cnt;
    logic [1:0]         bidx;
    logic [RDLEN_W-1:0] rdleft;
    logic [31:0]        inst_r, addr_r;
    logic [2:0]         icnt_r, acnt_r, dcnt_r;
    logic [2:0]         ic_in, ac_in;
    logic [1:0]         hsel;
    logic               wf_empty;
    phase_t             go_ph, nxt_ph;

    function automatic logic [2:0] clamp_cnt(logic [2:0] v);
        return (v > 3'(HDR_MAX)) ? 3'(HDR_MAX) : v;
    endfunction

    function automatic phase_t seek(phase_t from, logic [4:0] nonempty);
        phase_t p;
        p = PH_IDLE;
        for (int k = 4; k >= 0; k--) begin
            if (k >= int'(from) && nonempty[k]) p = phase_t'(3'(k + 1));
        end
        return p;
    endfunction

    function automatic logic [2:0] cnt_for(phase_t p, logic [2:0] i, logic [2:0] a,
                                           logic [2:0] d);
        case (p)
            PH_INST:  return i;
            PH_ADDR:  return a;
            PH_DUMMY: return d;
            default:  return 3'd0;
        endcase
    endfunction

    assign wf_empty = (wf_count == '0);
    assign ic_in    = clamp_cnt(inst_cnt);
    assign ac_in    = clamp_cnt(addr_cnt);
    assign go_ph    = seek(PH_IDLE, {rd_len != '0, !wf_empty, dummy_cnt != 3'd0,
                                     ac_in != 3'd0, ic_in != 3'd0});
    assign nxt_ph   = seek(state, {rdleft != '0, !wf_empty, dcnt_r != 3'd0,
                                   acnt_r != 3'd0, icnt_r != 3'd0});

    // state register and per-phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            launched <= 1'b0;
            cnt      <= '0;
            bidx     <= '0;
            rdleft   <= '0;
            inst_r   <= '0;
            addr_r   <= '0;
            icnt_r   <= '0;
            acnt_r   <= '0;
            dcnt_r   <= '0;
        end else if (state == PH_IDLE) begin
            launched <= 1'b0;
            if (go) begin
                inst_r <= inst_data;
                addr_r <= addr_data;
                icnt_r <= ic_in;
                acnt_r <= ac_in;
                dcnt_r <= dummy_cnt;
                rdleft <= rd_len;
                bidx   <= '0;
                state  <= go_ph;
                cnt    <= cnt_for(go_ph, ic_in, ac_in, dummy_cnt);
            end
        end else if (!launched) begin
            launched <= 1'b1;
        end else if (eng_done) begin
            launched <= 1'b0;
            unique case (state)
                PH_INST, PH_ADDR, PH_DUMMY: begin
                    if (cnt > 3'd1) begin
                        cnt <= cnt - 3'd1;
                    end else begin
                        state <= nxt_ph;
                        cnt   <= cnt_for(nxt_ph, icnt_r, acnt_r, dcnt_r);
                    end
                end
                PH_DATA: begin
                    bidx <= bidx + 2'd1;
                    if (bidx == 2'd3 && wf_count <= WCNT_W'(1)) state <= nxt_ph;
                end
                PH_READ: begin
                    if (rdleft > RDLEN_W'(1)) rdleft <= rdleft - RDLEN_W'(1);
                    else begin
                        rdleft <= '0;
                        state  <= PH_IDLE;
                    end
                end
                PH_IDLE: ;
            endcase
        end
    end

    assign hsel = cnt[1:0] - 2'd1;

    // outputs
    always_comb begin
        eng_start = (state != PH_IDLE) && !launched;
        wf_pop    = 1'b0;
        rf_push   = 1'b0;
        rf_wdata  = eng_rx;
        eng_tx    = 8'hFF;
        ready     = (state == PH_IDLE);
        unique case (state)
            PH_IDLE:  ;
            PH_INST:  eng_tx = inst_r[{hsel, 3'b000} +: 8];
            PH_ADDR:  eng_tx = addr_r[{hsel, 3'b000} +: 8];
            PH_DUMMY: eng_tx = 8'hFF;
            PH_DATA: begin
                eng_tx = wf_rdata[{bidx, 3'b000} +: 8];
                wf_pop = launched && eng_done && (bidx == 2'd3);
            end
            PH_READ: begin
                eng_tx  = 8'hFF;
                rf_push = launched && eng_done;
            end
        endcase
    end

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !eng_busy);

    assert_data_has_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_DATA) |-> !wf_empty);

    assert_start_when_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);
endmodule

// File: rtl/spi_hdr_master.sv
module spi_hdr_master #(
    parameter int WF_DEPTH = 8,
    parameter int RF_DEPTH = 16,
    parameter int DIV_W    = 4,
    parameter int RDLEN_W  = 6,
    localparam int WCNT_W  = $clog2(WF_DEPTH) + 1,
    localparam int RCNT_W  = $clog2(RF_DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_en,
    input  logic               cap_fall,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic [31:0]        inst_data,
    input  logic [2:0]         inst_cnt,
    input  logic [31:0]        addr_data,
    input  logic [2:0]         addr_cnt,
    input  logic [2:0]         dummy_cnt,
    input  logic [RDLEN_W-1:0] rd_len,
    input  logic               go,
    input  logic               flush,
    input  logic               wf_wr,
    input  logic [31:0]        wf_wdata,
    output logic               wf_full,
    input  logic               rf_rd,
    output logic [7:0]         rf_rdata,
    output logic               rf_empty,
    output logic               ready,
    output logic               spi_sclk,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    logic [31:0]       wf_rdata;
    logic [WCNT_W-1:0] wf_count;
    logic [RCNT_W-1:0] rf_count;
    logic              wf_pop, rf_push, rf_full;
    logic [7:0]        rf_wdata;
    logic              eng_start, eng_busy, eng_done;
    logic [7:0]        eng_tx, eng_rx;

    assign spi_cs_n = ~cs_en;
    assign rf_empty = (rf_count == '0);

    spi_hdr_fifo #(.W(32), .DEPTH(WF_DEPTH)) u_wfifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(wf_wr), .wdata(wf_wdata),
        .pop(wf_pop), .rdata(wf_rdata),
        .full(wf_full), .count(wf_count)
    );

    spi_hdr_fifo #(.W(8), .DEPTH(RF_DEPTH)) u_rfifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rf_push), .wdata(rf_wdata),
        .pop(rf_rd), .rdata(rf_rdata),
        .full(rf_full), .count(rf_count)
    );

    spi_hdr_byte_eng #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .tx_byte(eng_tx),
        .div(clk_div), .cap_fall(cap_fall), .miso(spi_miso),
        .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    spi_hdr_ctrl #(.RDLEN_W(RDLEN_W), .WCNT_W(WCNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go),
        .inst_data(inst_data), .inst_cnt(inst_cnt),
        .addr_data(addr_data), .addr_cnt(addr_cnt),
        .dummy_cnt(dummy_cnt), .rd_len(rd_len),
        .wf_rdata(wf_rdata), .wf_count(wf_count), .wf_pop(wf_pop),
        .rf_push(rf_push), .rf_wdata(rf_wdata),
        .eng_start(eng_start), .eng_tx(eng_tx),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx),
        .ready(ready)
    );

    assert_cs_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n != cs_en);

    assert_rf_push_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_push && rf_full) |=> rf_count == $past(rf_count));
endmodule

// File: tb/sim_spi_hdr_master.sv
`timescale 1ns/1ps
module sim_spi_hdr_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_en = 1'b0, cap_fall = 1'b0;
    logic [3:0]  clk_div = '0;
    logic [31:0] inst_data = '0, addr_data = '0, wf_wdata = '0;
    logic [2:0]  inst_cnt = '0, addr_cnt = '0, dummy_cnt = '0;
    logic [5:0]  rd_len = '0;
    logic        go = 1'b0, flush = 1'b0, wf_wr = 1'b0, rf_rd = 1'b0;
    logic        wf_full, rf_empty, ready, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic [7:0]  rf_rdata;

    always #2 clk = ~clk;

    spi_hdr_master u0 (
        .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .cap_fall(cap_fall),
        .clk_div(clk_div), .inst_data(inst_data), .inst_cnt(inst_cnt),
        .addr_data(addr_data), .addr_cnt(addr_cnt), .dummy_cnt(dummy_cnt),
        .rd_len(rd_len), .go(go), .flush(flush), .wf_wr(wf_wr),
        .wf_wdata(wf_wdata), .wf_full(wf_full), .rf_rd(rf_rd),
        .rf_rdata(rf_rdata), .rf_empty(rf_empty), .ready(ready),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int total = 0, fails = 0;
    int npos = 0, nneg = 0, nhigh = 0;
    int base_pos = 0, base_neg = 0, base_high = 0;
    int seed = 1;
    logic [7:0]  acc = '0;
    logic [7:0]  got [64];
    logic [7:0]  exp_b [64];
    logic [31:0] wq [8];
    int wn = 0;
    logic miso_pos = 1'b1;

    function automatic logic bitval(int i);
        return 1'(((i * 37) + ((i >> 3) * 11)) >> 2);
    endfunction

    // serial slave: MOSI capture and MISO pattern
    always @(posedge spi_sclk) begin : mon
        int k;
        k = npos - base_pos;
        acc = {acc[6:0], spi_mosi};
        if ((k % 8) == 7 && (k / 8) < 64) got[k / 8] = acc;
        miso_pos <= bitval(k);
        npos++;
    end
    always @(negedge spi_sclk) nneg++;
    always @(posedge clk) if (spi_sclk) nhigh++;
    assign spi_miso = cap_fall ? miso_pos : bitval(nneg - base_neg);

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = (32'(seed) * 32'h9E3779B9) + 32'h01234567;
            seed++;
            if (wn == 8) chk(wf_full == 1'b1, "R5 full flag", wf_full, 1);
            if (wn < 8) begin
                wq[wn] = w;
                wn++;
            end
            wf_wr = 1'b1;
            wf_wdata = w;
            @(negedge clk);
            wf_wr = 1'b0;
        end
    endtask

    task automatic run_xfer(input int ic, input logic [31:0] iv, input int ac,
                            input logic [31:0] av, input int dc, input int rd,
                            input bit cf, input int dv, input bit drain, input bit again);
        int ne, ntx, t;
        string tag;
        ne = 0;
        for (int b = ic - 1; b >= 0; b--) begin exp_b[ne] = iv[8*b +: 8]; ne++; end
        for (int b = ac - 1; b >= 0; b--) begin exp_b[ne] = av[8*b +: 8]; ne++; end
        for (int b = 0; b < dc; b++) begin exp_b[ne] = 8'hFF; ne++; end
        for (int w = 0; w < wn; w++)
            for (int b = 0; b < 4; b++) begin exp_b[ne] = wq[w][8*b +: 8]; ne++; end
        ntx = ne;
        for (int b = 0; b < rd; b++) begin exp_b[ne] = 8'hFF; ne++; end

        inst_cnt = 3'(ic); inst_data = iv; addr_cnt = 3'(ac); addr_data = av;
        dummy_cnt = 3'(dc); rd_len = 6'(rd); cap_fall = cf; clk_div = 4'(dv);
        base_pos = npos; base_neg = nneg; base_high = nhigh;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        if (ne > 0) chk(ready == 1'b0, "R8 ready drops after go", ready, 0);
        if (again) begin
            repeat (20) @(negedge clk);
            go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        t = 0;
        while (!ready && t < 20000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
        chk((npos - base_pos) == ne * 8, "R1 bit count", npos - base_pos, ne * 8);
        for (int i = 0; i < ne && i < 64; i++) begin
            if (i < ic + ac)      tag = "R2 header byte";
            else if (i < ic + ac + dc) tag = "R3 dummy byte";
            else if (i < ntx)     tag = "R4 data byte";
            else                  tag = "R7 read mosi byte";
            chk(got[i] == exp_b[i], tag, got[i], exp_b[i]);
        end
        chk((nhigh - base_high) == ne * 8 * (dv + 1), "R10 high time",
            nhigh - base_high, ne * 8 * (dv + 1));
        chk(spi_sclk == 1'b0, "R10 sclk idle", spi_sclk, 0);
        if (drain && rd > 0) begin
            for (int k = 0; k < rd; k++) begin
                logic [7:0] e;
                for (int b = 0; b < 8; b++) e[7-b] = bitval((ntx + k) * 8 + b);
                chk(rf_empty == 1'b0, "R7 read fifo holds byte", rf_empty, 0);
                chk(rf_rdata == e, cf ? "R9 falling capture" : "R7 rising capture",
                    rf_rdata, e);
                rf_rd = 1'b1;
                @(negedge clk);
                rf_rd = 1'b0;
            end
            chk(rf_empty == 1'b1, "R7 read count", rf_empty, 1);
        end
        wn = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R11 ready", ready, 1);
        chk(spi_sclk == 1'b0, "R11 sclk", spi_sclk, 0);
        chk(spi_mosi == 1'b1, "R11 mosi", spi_mosi, 1);
        chk(wf_full == 1'b0, "R11 wf_full", wf_full, 0);
        chk(rf_empty == 1'b1, "R11 rf_empty", rf_empty, 1);
        chk(spi_cs_n == 1'b1, "R12 cs idle", spi_cs_n, 1);
        cs_en = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b0, "R12 cs active", spi_cs_n, 0);

        n = 0;
        for (int ic = 0; ic <= 2; ic++)
            for (int ac = 0; ac <= 4; ac++)
                for (int dc = 0; dc <= 1; dc++)
                    for (int nw = 0; nw <= 2; nw++)
                        for (int r = 0; r <= 1; r++) begin
                            push_words(nw);
                            run_xfer(ic, 32'hC3A5_5A00 + 32'(n), ac,
                                     32'h1122_3344 ^ 32'(n * 7), dc, r * 3,
                                     1'(n % 2), (n / 2) % 2, 1'b1, 1'b0);
                            n++;
                        end

        // full FIFO: ninth word dropped
        push_words(9);
        run_xfer(0, 0, 0, 0, 0, 0, 1'b0, 0, 1'b1, 1'b0);
        chk(wf_full == 1'b0, "R5 drained", wf_full, 0);

        // flush empties both FIFOs
        run_xfer(1, 32'h0000_009C, 0, 0, 0, 2, 1'b0, 0, 1'b0, 1'b0);
        chk(rf_empty == 1'b0, "R6 unread bytes present", rf_empty, 0);
        push_words(3);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        wn = 0;
        chk(rf_empty == 1'b1, "R6 read fifo flushed", rf_empty, 1);
        run_xfer(0, 0, 0, 0, 0, 0, 1'b0, 0, 1'b1, 1'b0);
        chk((npos - base_pos) == 0, "R6 write fifo flushed", npos - base_pos, 0);

        // go during a transfer is ignored
        push_words(2);
        run_xfer(2, 32'h0000_A1B2, 3, 32'h00C4_D5E6, 1, 1, 1'b1, 1, 1'b1, 1'b1);

        cs_en = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R12 cs released", spi_cs_n, 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule